// File: doc/BRIEF.md
# Framebuffer Scan-Out Burst Address Generator

This block walks one video frame stored in memory and produces the read bursts needed to fetch it, one burst request at a time, for a display output. A frame is either a single packed plane (16-bit or 32-bit pixels) or a planar 4:2:0 image. The planar image keeps luma, blue-difference and red-difference samples in three separate regions. No stride register exists. The distance between two lines is the active width of the chosen resolution class times the bytes each sample takes. Every burst moves at most 32 words of 4 bytes. The final burst of a line carries only the words that remain.

Software writes three plane start addresses, a resolution code and a pixel-format code. It then pulses `frame_start` once per frame. The start addresses and both codes are sampled only on that pulse, so values written during a frame cannot tear the image being fetched. Requests use a valid/ready handshake. The bus may also refuse a request; the block then re-issues it, and after too many refusals it gives up on that burst, raises a sticky error flag and moves to the next burst.

The controller has three states. IDLE waits for a frame. LOAD spends one cycle turning the sampled codes into line sizes and strides. ISSUE presents bursts. The transitions are:
- start: any state to LOAD, when `frame_start` is high.
- prepared: LOAD to ISSUE, always after one cycle.
- drained: ISSUE to IDLE, when the final burst of the final line is accepted or skipped.

Top module: `fb_scan_agen`

## Requirements
- R1: After reset `req_valid` and `retry_err` are 0. A high `req_ready` in IDLE produces no request.
- R2: Resolution code `res_mode` selects width x lines: 0 = 352x240, 1 = 352x288, 2 = 640x480, 3 = 720x480, 4 = 720x576. Codes 5, 6 and 7 behave exactly like code 0.
- R3: Format code `pix_fmt` selects the layout. 0 = packed, 2 bytes per pixel. 1 = packed, 4 bytes per pixel. 2 = planar 4:2:0, 1 byte per luma sample. Code 3 behaves exactly like code 1. The luma (or packed) line stride in bytes is width x bytes per pixel.
- R4: A line of N words is split into bursts of 32 words. When N is not a multiple of 32, the last burst of the line has `req_len` = N mod 32. Within a line, each burst address is 128 bytes above the previous one. `req_len` is the word count, from 1 to 32.
- R5: In planar mode, every even luma line r (counting from 0) is followed by line r/2 of the U plane and then line r/2 of the V plane. Each chroma line is width/2 bytes long and uses stride width/2. The U and V start addresses are used only in planar mode.
- R6: Bits [1:0] of every start address are treated as zero. Every `req_addr` therefore has bits [1:0] = 0.
- R7: While `req_valid` is high and the request is neither accepted nor skipped, `req_valid`, `req_addr` and `req_len` hold steady. An accept happens on a cycle with `req_ready` high.
- R8: A cycle with `req_refuse` high and `req_ready` low is a refusal. After 16 consecutive refusals have been retried, a 17th refusal drops the burst and the next burst follows. `retry_err` goes to 1 the cycle after the drop and stays 1 until the next `frame_start`. An accept clears the refusal count.
- R9: Start addresses and both codes are sampled only on a `frame_start` cycle. Changes at other times have no effect on the frame in progress.
- R10: The first request of a frame is valid two clock edges after the edge that samples `frame_start`. `req_valid` drops the cycle after the last burst completes. A `frame_start` in mid-frame abandons the current frame and restarts with the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame and samples the settings |
| base_y | input | ADDR_W | Start address of the luma (or packed) plane |
| base_u | input | ADDR_W | Start address of the U plane (planar only) |
| base_v | input | ADDR_W | Start address of the V plane (planar only) |
| res_mode | input | 3 | Resolution class code |
| pix_fmt | input | 2 | Pixel layout code |
| req_ready | input | 1 | Bus accepts the presented burst |
| req_refuse | input | 1 | Bus refuses the presented burst |
| req_valid | output | 1 | A burst request is presented |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_len | output | LEN_W | Burst length in 32-bit words |
| retry_err | output | 1 | Sticky flag: a burst was dropped after exhausting its retries |

## Verification
Results fall due on a fixed cycle grid. The first request of a frame appears two edges after `frame_start` is sampled. Each accept or drop moves the presented burst one edge later. The error flag follows a drop by one edge, and `req_valid` falls one edge after the final burst. The bench holds a queue of expected bursts built from the width, stride and ordering rules when `frame_start` is sent, and it models the LOAD gap and the refusal count. At every falling edge it compares valid, address, length and the error flag with that model, so every result is checked on the cycle it falls due. Stimulus covers steady acceptance, stalls on alternate cycles, refusals that end in an accept on the 16th retry and refusals that run out, address changes during a frame, the aliased codes and a restart in mid-frame.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int LW_W  = 12;   // width of a per-line word count
    localparam int ROW_W = 10;   // width of a line index

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ISSUE = 2'd2
    } st_e;

    typedef enum logic [1:0] {
        PL_Y = 2'd0,
        PL_U = 2'd1,
        PL_V = 2'd2
    } plane_e;

    typedef struct packed {
        logic [LW_W-1:0]  y_words;
        logic [LW_W-1:0]  c_words;
        logic [LW_W+1:0]  y_pitch;
        logic [LW_W+1:0]  c_pitch;
        logic [ROW_W-1:0] rows;
        logic             planar;
    } geom_t;

endpackage

// File: rtl/fbs_geom.sv
module fbs_geom
    import fbs_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] fmt,
    output geom_t      geom
);

    logic [ROW_W-1:0] width;
    logic [ROW_W-1:0] rows;
    logic [1:0]       shift;
    logic [LW_W-1:0]  line_bytes;
    logic [LW_W-1:0]  y_words;
    logic [LW_W-1:0]  c_words;
    logic             planar;

    always_comb begin
        case (mode)
            3'd1:    begin width = 10'd352; rows = 10'd288; end
            3'd2:    begin width = 10'd640; rows = 10'd480; end
            3'd3:    begin width = 10'd720; rows = 10'd480; end
            3'd4:    begin width = 10'd720; rows = 10'd576; end
            default: begin width = 10'd352; rows = 10'd240; end
        endcase

        case (fmt)
            2'd0:    shift = 2'd1;
            2'd2:    shift = 2'd0;
            default: shift = 2'd2;
        endcase

        planar     = (fmt == 2'd2);
        line_bytes = LW_W'(width) << shift;
        y_words    = line_bytes >> 2;
        c_words    = planar ? LW_W'(width >> 3) : '0;

        geom.y_words = y_words;
        geom.c_words = c_words;
        geom.y_pitch = {y_words, 2'b00};
        geom.c_pitch = {c_words, 2'b00};
        geom.rows    = rows;
        geom.planar  = planar;
    end

endmodule

// File: rtl/fbs_retry.sv
module fbs_retry #(
    parameter int RETRY_MAX = 16,
    localparam int CNT_W = $clog2(RETRY_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic refuse,
    output logic exhausted
);

    logic [CNT_W-1:0] cnt;

    assign exhausted = refuse && (cnt == CNT_W'(RETRY_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (refuse) begin
            cnt <= exhausted ? '0 : cnt + 1'b1;
        end
    end

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(RETRY_MAX)); // R8

    AST_RETRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8

endmodule

// File: rtl/fb_scan_agen.sv
module fb_scan_agen
    import fbs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_WORDS = 32,
    parameter int RETRY_MAX   = 16,
    localparam int LEN_W = $clog2(BURST_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] base_y,
    input  logic [ADDR_W-1:0] base_u,
    input  logic [ADDR_W-1:0] base_v,
    input  logic [2:0]        res_mode,
    input  logic [1:0]        pix_fmt,
    input  logic              req_ready,
    input  logic              req_refuse,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic              retry_err
);

    localparam int NPLANE = 3;

    st_e              state, state_n;
    plane_e           plane;
    logic [2:0]       mode_q;
    logic [1:0]       fmt_q;
    geom_t            g_comb, g_q;
    logic [ROW_W-1:0] row;
    logic [LW_W-1:0]  off;

    logic [LW_W-1:0]   cur_words, remain;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] cur_ptr;
    logic accept, refuse_eff, exhausted, step;
    logic line_end, row_inc, last_row, chroma_next, frame_end;

    fbs_geom u_geom (
        .mode (mode_q),
        .fmt  (fmt_q),
        .geom (g_comb)
    );

    fbs_retry #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept | frame_start),
        .refuse    (refuse_eff),
        .exhausted (exhausted)
    );

    // burst sizing and walk decisions
    always_comb begin
        cur_words   = (plane == PL_Y) ? g_q.y_words : g_q.c_words;
        remain      = cur_words - off;
        len         = (remain >= LW_W'(BURST_WORDS)) ? LEN_W'(BURST_WORDS) : LEN_W'(remain);
        accept      = (state == ST_ISSUE) && req_ready && !frame_start;
        refuse_eff  = (state == ST_ISSUE) && req_refuse && !req_ready && !frame_start;
        step        = accept || exhausted;
        line_end    = step && ((off + LW_W'(len)) >= cur_words);
        last_row    = (row == g_q.rows - 10'd1);
        chroma_next = g_q.planar && !row[0];
        row_inc     = line_end && (((plane == PL_Y) && !chroma_next) || (plane == PL_V));
        frame_end   = row_inc && last_row;
    end

    // per-plane active line pointers, loaded from the staged bases at frame start
    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [ADDR_W-1:0] ptr_q;
        logic [ADDR_W-1:0] base_in;
        logic [ADDR_W-1:0] pitch;
        logic              adv;

        assign base_in = (p == 0) ? base_y : ((p == 1) ? base_u : base_v);
        assign pitch   = (p == 0) ? ADDR_W'(g_q.y_pitch) : ADDR_W'(g_q.c_pitch);
        assign adv     = (p == 0) ? row_inc : (line_end && (plane == PL_V));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q <= '0;
            end else if (frame_start) begin
                ptr_q <= base_in & ~ADDR_W'(3);
            end else if (adv) begin
                ptr_q <= ptr_q + pitch;
            end
        end
    end

    always_comb begin
        unique case (plane)
            PL_U:    cur_ptr = g_plane[1].ptr_q;
            PL_V:    cur_ptr = g_plane[2].ptr_q;
            default: cur_ptr = g_plane[0].ptr_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        if (frame_start) begin
            state_n = ST_LOAD;
        end else begin
            unique case (state)
                ST_IDLE:  state_n = ST_IDLE;
                ST_LOAD:  state_n = ST_ISSUE;
                ST_ISSUE: if (frame_end) state_n = ST_IDLE;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_valid = (state == ST_ISSUE);
        req_addr  = cur_ptr + ADDR_W'({off, 2'b00});
        req_len   = len;
    end

    // walk position, sampled settings, error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            fmt_q     <= '0;
            g_q       <= '0;
            row       <= '0;
            off       <= '0;
            plane     <= PL_Y;
            retry_err <= 1'b0;
        end else if (frame_start) begin
            mode_q    <= res_mode;
            fmt_q     <= pix_fmt;
            row       <= '0;
            off       <= '0;
            plane     <= PL_Y;
            retry_err <= 1'b0;
        end else begin
            if (state == ST_LOAD) g_q <= g_comb;
            if (exhausted) retry_err <= 1'b1;
            if (step) begin
                if (!line_end) begin
                    off <= off + LW_W'(len);
                end else begin
                    off <= '0;
                    unique case (plane)
                        PL_Y: begin
                            if (chroma_next) plane <= PL_U;
                            else             row   <= row + 1'b1;
                        end
                        PL_U: plane <= PL_V;
                        PL_V: begin
                            plane <= PL_Y;
                            row   <= row + 1'b1;
                        end
                        default: plane <= PL_Y;
                    endcase
                end
            end
        end
    end

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (req_len <= LEN_W'(BURST_WORDS))); // R4

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00)); // R6

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !exhausted && !frame_start)
        |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R7

    AST_ERR_ON_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && !frame_start) |=> retry_err); // R8

    AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !req_valid); // R10

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !retry_err); // R8

endmodule

// File: tb/fb_scan_agen_test.sv
module fb_scan_agen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [31:0] base_y = '0, base_u = '0, base_v = '0;
    logic [2:0]  res_mode = '0;
    logic [1:0]  pix_fmt = '0;
    logic        req_ready = 1'b0, req_refuse = 1'b0;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [5:0]  req_len;
    logic        retry_err;

    always #5 clk = ~clk;

    fb_scan_agen uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .base_y(base_y), .base_u(base_u), .base_v(base_v),
        .res_mode(res_mode), .pix_fmt(pix_fmt),
        .req_ready(req_ready), .req_refuse(req_refuse),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .retry_err(retry_err)
    );

    int checks = 0, errors = 0, cyc = 0, wd = 0;
    logic [31:0] q_addr[$];
    int          q_len[$];
    int ld = 0, rcnt = 0, pops = 0, pat = 0, restart_at = 0;
    bit exp_err = 0, mid_chg = 0, chg_done = 0, restarted = 0;
    logic [31:0] cur_by, cur_bu, cur_bv;
    int cur_mode, cur_fmt;

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic emit(input logic [31:0] a, input int words);
        for (int o = 0; o < words; o += 32) begin
            q_addr.push_back(a + 32'(o * 4));
            q_len.push_back((words - o) > 32 ? 32 : words - o);
        end
    endtask

    // expected burst list from the width, stride and ordering rules
    task automatic build();
        int w, h, b;
        logic [31:0] by, bu, bv;
        case (cur_mode)
            1: begin w = 352; h = 288; end
            2: begin w = 640; h = 480; end
            3: begin w = 720; h = 480; end
            4: begin w = 720; h = 576; end
            default: begin w = 352; h = 240; end
        endcase
        case (cur_fmt)
            0: b = 2;
            2: b = 1;
            default: b = 4;
        endcase
        by = cur_by & 32'hFFFF_FFFC;
        bu = cur_bu & 32'hFFFF_FFFC;
        bv = cur_bv & 32'hFFFF_FFFC;
        q_addr.delete();
        q_len.delete();
        for (int r = 0; r < h; r++) begin
            emit(by + 32'(r * w * b), (w * b) / 4);
            if (cur_fmt == 2 && (r % 2) == 0) begin
                emit(bu + 32'((r / 2) * (w / 2)), w / 8);
                emit(bv + 32'((r / 2) * (w / 2)), w / 8);
            end
        end
    endtask

    task automatic tick(input bit fs_in, input string tag);
        bit ev, rdy, rfs, fs;
        @(negedge clk);
        ev = (ld == 0) && (q_addr.size() > 0);
        chk(req_valid === ev, "R10", "req_valid", req_valid, ev);
        if (ev && req_valid === 1'b1) begin
            chk(req_addr === q_addr[0], tag, "req_addr", req_addr, q_addr[0]);
            chk(req_len === 6'(q_len[0]), tag, "req_len", req_len, q_len[0]);
            chk(req_addr[1:0] === 2'b00, "R6", "req_addr low bits", req_addr[1:0], 0);
        end
        chk(retry_err === exp_err, "R8", "retry_err", retry_err, exp_err);

        fs = fs_in;
        if (restart_at > 0 && !restarted && pops == restart_at) begin
            fs = 1;
            restarted = 1;
            cur_by = cur_by + 32'h0010_0000;
            cur_mode = 2;
        end
        case (pat)
            1: begin rdy = cyc[0]; rfs = 0; end
            2: begin
                if (pops == 5)       begin rdy = 0; rfs = 1; end
                else if (pops == 10) begin rdy = (rcnt == 16); rfs = !rdy; end
                else                 begin rdy = (cyc % 3 != 1); rfs = !rdy; end
            end
            default: begin rdy = 1; rfs = 0; end
        endcase
        frame_start = fs;
        req_ready   = rdy;
        req_refuse  = rfs;
        if (fs) begin
            base_y = cur_by; base_u = cur_bu; base_v = cur_bv;
            res_mode = 3'(cur_mode); pix_fmt = 2'(cur_fmt);
        end
        if (mid_chg && !chg_done && pops == 50) begin
            base_y = 32'hDEAD_0000; base_u = 32'hBEEF_0000; base_v = 32'hCAFE_0000;
            res_mode = 3'd4; pix_fmt = 2'd2;
            chg_done = 1;
        end

        if (ld > 0) ld--;
        if (fs) begin
            build();
            ld = 1; rcnt = 0; exp_err = 0; pops = 0;
        end else if (ev) begin
            if (rdy) begin
                void'(q_addr.pop_front()); void'(q_len.pop_front());
                pops++; rcnt = 0;
            end else if (rfs) begin
                if (rcnt == 16) begin
                    void'(q_addr.pop_front()); void'(q_len.pop_front());
                    pops++; rcnt = 0; exp_err = 1;
                end else begin
                    rcnt++;
                end
            end
        end
        cyc++;
    endtask

    task automatic run_frame(input int m, input int f, input logic [31:0] by,
                             input logic [31:0] bu, input logic [31:0] bv,
                             input int p, input string tag);
        cur_mode = m; cur_fmt = f; cur_by = by; cur_bu = bu; cur_bv = bv;
        pat = p;
        tick(1, tag);
        while (ld > 0 || q_addr.size() > 0) tick(0, tag);
        tick(0, tag);
        tick(0, tag);
        chk(req_valid === 1'b0, "R10", "idle after frame", req_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_valid === 1'b0, "R1", "req_valid after reset", req_valid, 0);
        chk(retry_err === 1'b0, "R1", "retry_err after reset", retry_err, 0);
        req_ready = 1'b1;
        repeat (3) tick(0, "R1");
        chk(req_valid === 1'b0, "R1", "ready in idle", req_valid, 0);

        // CIF 240 lines, 16-bit packed: 5 full bursts plus a 16-word tail per line
        run_frame(0, 0, 32'h1000_0000, 32'h0, 32'h0, 0, "R2");
        // VGA, 32-bit, stalls on alternate cycles, settings changed mid-frame
        mid_chg = 1; chg_done = 0;
        run_frame(2, 1, 32'h2000_0000, 32'h0, 32'h0, 1, "R9");
        mid_chg = 0;
        chk(chg_done == 1, "R9", "mid-frame change applied", chg_done, 1);
        // D1 576 planar 4:2:0
        run_frame(4, 2, 32'h3000_0000, 32'h3100_0000, 32'h3200_0000, 0, "R5");
        // D1 480, 16-bit: 8-word tail per line
        run_frame(3, 0, 32'h4000_0000, 32'h0, 32'h0, 0, "R4");
        // CIF 288, 32-bit, refusals incl. one exhausted burst
        run_frame(1, 1, 32'h5000_0000, 32'h0, 32'h0, 2, "R8");
        chk(retry_err === 1'b1, "R8", "sticky error at frame end", retry_err, 1);
        // aliased codes, misaligned base: error must clear at start
        run_frame(5, 3, 32'h6000_0003, 32'h0, 32'h0, 0, "R3");
        chk(retry_err === 1'b0, "R8", "error cleared by new frame", retry_err, 0);
        // restart mid-frame with new base and resolution
        restart_at = 30; restarted = 0;
        run_frame(0, 2, 32'h7000_0002, 32'h7100_0001, 32'h7200_0000, 0, "R10");
        restart_at = 0;
        chk(restarted == 1, "R10", "restart issued", restarted, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule